// File: doc/BRIEF.md
# PS/2 Host Receive Engine

This block is the receiving half of a PS/2 host port. It watches the open-collector clock and data lines driven by a keyboard or mouse. It recognises a start bit, then collects eight data bits with the least significant bit first, followed by a parity bit and a stop bit. Each bit is taken on a falling edge of the device clock. Once the device lets its clock return high, the block checks the frame. It then either presents the byte with a one-cycle valid strobe or raises a one-cycle error strobe.

Both pins first pass through a two-flop synchronizer. They are then sampled only on an internal periodic tick of about 3 microseconds, derived from the system clock by `TICK_DIV`. A falling clock edge is declared only when two consecutive tick samples go from high to low. This filters short glitches cheaply.

A frame timer starts at the start bit. If it runs out before the frame is accepted, the partial byte is dropped, a timeout strobe is pulsed and the engine returns to idle.

The engine has five named states:
- **RX_IDLE** moves to **RX_DATA** on a falling edge seen with data low.
- **RX_DATA** moves to **RX_PARITY** on the eighth data edge.
- **RX_PARITY** moves to **RX_STOP** on its edge.
- **RX_STOP** moves to **RX_WAIT_HIGH** on the stop edge.
- **RX_WAIT_HIGH** moves to **RX_IDLE** when a tick sees the clock high. The frame is checked on this transition.

Any state other than RX_IDLE moves to RX_IDLE when the timer expires, and this transition takes priority.

Top module: `ps2_rx_engine`

## Requirements
- R1: After reset, `rx_valid_o`, `rx_err_o` and `rx_timeout_o` are low, `rx_byte_o` is 0x00 and the engine is idle.
- R2: A frame starts only on a tick-sampled falling edge of the PS/2 clock while data is low. A falling edge seen in idle with data high is ignored and does not disturb the next frame.
- R3: The eight data bits taken on the following falling edges form `rx_byte_o`, with the first bit as bit 0. A good frame produces exactly one `rx_valid_o` pulse carrying that byte.
- R4: Parity is odd: the eight data bits plus the parity bit must contain an odd number of ones. A frame failing this gives exactly one `rx_err_o` pulse and no valid pulse.
- R5: A stop bit sampled as 0 gives exactly one `rx_err_o` pulse and no valid pulse.
- R6: The valid or error strobe of a frame is issued only after the PS/2 clock has been sampled high following the stop-bit edge. While the clock is held low after that edge, no strobe appears.
- R7: If `TIMEOUT_TICKS` ticks pass after the start bit before the frame is accepted, the partial frame is discarded and `rx_timeout_o` pulses once. The engine returns to idle and receives the next frame normally.
- R8: `rx_byte_o` changes only in a cycle where `rx_valid_o` is high. It keeps its value across error and timeout outcomes.
- R9: `rx_valid_o`, `rx_err_o` and `rx_timeout_o` are never high together, and each is high for a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ps2_clk_i | input | 1 | PS/2 clock line level (asynchronous) |
| ps2_dat_i | input | 1 | PS/2 data line level (asynchronous) |
| rx_byte_o | output | 8 | Last correctly received byte |
| rx_valid_o | output | 1 | One-cycle strobe: new byte on `rx_byte_o` |
| rx_err_o | output | 1 | One-cycle strobe: parity or stop-bit failure |
| rx_timeout_o | output | 1 | One-cycle strobe: frame abandoned on timeout |

## Verification
Some internal faults misalign the bit counter or the state. For example, a start taken on an edge with data high, or one edge too many or too few in RX_DATA. Such faults show up at the ports within the frame that follows: either a byte shifted by one position, or an error strobe in place of a valid one. Both are visible about one PS/2 bit time after the clock returns high.

A timer that is not cleared or not armed shows as a missing or early timeout strobe, one timeout period after the start bit. A wrong strobe condition in RX_WAIT_HIGH shows as a strobe that appears while the clock is still held low.

// File: rtl/ps2_rx_pkg.sv
package ps2_rx_pkg;
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_DATA,
        RX_PARITY,
        RX_STOP,
        RX_WAIT_HIGH
    } rx_state_t;
endpackage

// File: rtl/ps2_tick_gen.sv
module ps2_tick_gen #(
    parameter int TICK_DIV = 150
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = $clog2(TICK_DIV + 1);
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick_o = (cnt == LAST);
endmodule

// File: rtl/ps2_pin_sync.sv
module ps2_pin_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic pin_clk_i,
    input  logic pin_dat_i,
    output logic fall_o,
    output logic clk_high_o,
    output logic dat_o
);
    localparam int NPINS = 2;

    logic [NPINS-1:0] pins_raw;
    logic [NPINS-1:0] pins_sync;
    logic             samp_clk;

    assign pins_raw = {pin_dat_i, pin_clk_i};

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic [SYNC_STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= '1;
            end else begin
                chain <= {chain[SYNC_STAGES-2:0], pins_raw[p]};
            end
        end
        assign pins_sync[p] = chain[SYNC_STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_clk <= 1'b1;
        end else if (tick_i) begin
            samp_clk <= pins_sync[0];
        end
    end

    assign fall_o     = tick_i & samp_clk & ~pins_sync[0];
    assign clk_high_o = tick_i & pins_sync[0];
    assign dat_o      = pins_sync[1];
endmodule

// File: rtl/ps2_frame_timer.sv
module ps2_frame_timer #(
    parameter int TIMEOUT_TICKS = 667
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic start_i,
    input  logic run_i,
    output logic expire_o
);
    localparam int TW = $clog2(TIMEOUT_TICKS + 1);
    localparam logic [TW-1:0] LAST = TW'(TIMEOUT_TICKS - 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || start_i) begin
            cnt <= '0;
        end else if (run_i && tick_i && cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expire_o = run_i & tick_i & (cnt == LAST);
endmodule

// File: rtl/ps2_rx_engine.sv
module ps2_rx_engine
    import ps2_rx_pkg::*;
#(
    parameter int TICK_DIV      = 150,
    parameter int TIMEOUT_TICKS = 667,
    parameter int SYNC_STAGES   = 2,
    parameter int DATA_BITS     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ps2_clk_i,
    input  logic                 ps2_dat_i,
    output logic [DATA_BITS-1:0] rx_byte_o,
    output logic                 rx_valid_o,
    output logic                 rx_err_o,
    output logic                 rx_timeout_o
);
    localparam int BCW = $clog2(DATA_BITS);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(DATA_BITS - 1);

    logic tick, fall, clk_high, dat, expire, start, run, frame_ok;
    rx_state_t state, nxt;
    logic [BCW-1:0]       bit_cnt;
    logic [DATA_BITS-1:0] shreg;
    logic                 par_bit, stop_bit;

    ps2_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    ps2_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .pin_clk_i(ps2_clk_i), .pin_dat_i(ps2_dat_i),
        .fall_o(fall), .clk_high_o(clk_high), .dat_o(dat)
    );

    ps2_frame_timer #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .start_i(start), .run_i(run), .expire_o(expire)
    );

    assign start    = (state == RX_IDLE) && fall && !dat;
    assign run      = (state != RX_IDLE);
    assign frame_ok = stop_bit && (^{shreg, par_bit});

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RX_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:      if (fall && !dat) nxt = RX_DATA;
            RX_DATA:      if (fall && bit_cnt == LAST_BIT) nxt = RX_PARITY;
            RX_PARITY:    if (fall) nxt = RX_STOP;
            RX_STOP:      if (fall) nxt = RX_WAIT_HIGH;
            RX_WAIT_HIGH: if (clk_high) nxt = RX_IDLE;
            default:      nxt = RX_IDLE;
        endcase
        if (run && expire) begin
            nxt = RX_IDLE;
        end
    end

    // datapath and output strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt      <= '0;
            shreg        <= '0;
            par_bit      <= 1'b0;
            stop_bit     <= 1'b0;
            rx_byte_o    <= '0;
            rx_valid_o   <= 1'b0;
            rx_err_o     <= 1'b0;
            rx_timeout_o <= 1'b0;
        end else begin
            rx_valid_o   <= 1'b0;
            rx_err_o     <= 1'b0;
            rx_timeout_o <= run && expire;
            unique case (state)
                RX_IDLE: bit_cnt <= '0;
                RX_DATA: if (fall) begin
                    shreg   <= {dat, shreg[DATA_BITS-1:1]};
                    bit_cnt <= bit_cnt + 1'b1;
                end
                RX_PARITY: if (fall) par_bit <= dat;
                RX_STOP:   if (fall) stop_bit <= dat;
                RX_WAIT_HIGH: if (clk_high && !expire) begin
                    if (frame_ok) begin
                        rx_valid_o <= 1'b1;
                        rx_byte_o  <= shreg;
                    end else begin
                        rx_err_o <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ps2_rx_checker.sv
module ps2_rx_checker
    import ps2_rx_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [DATA_BITS-1:0] rx_byte_o,
    input logic                 rx_valid_o,
    input logic                 rx_err_o,
    input logic                 rx_timeout_o,
    input rx_state_t            state
);
    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rx_valid_o, rx_err_o, rx_timeout_o}) <= 1); // R9
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o); // R9
    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err_o |=> !rx_err_o); // R9
    AST_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid_o |-> $stable(rx_byte_o)); // R8
    AST_VALID_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> $past(state) == RX_WAIT_HIGH); // R6
    AST_ERR_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err_o |-> $past(state) == RX_WAIT_HIGH); // R4
    AST_TIMEOUT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_timeout_o |-> state == RX_IDLE); // R7
endmodule

bind ps2_rx_engine ps2_rx_checker #(.DATA_BITS(DATA_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_byte_o(rx_byte_o),
    .rx_valid_o(rx_valid_o), .rx_err_o(rx_err_o),
    .rx_timeout_o(rx_timeout_o), .state(state)
);

// File: tb/ps2_rx_engine_test.sv
module ps2_rx_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int TMO_TICKS  = 200;
    localparam int HALF_CLKS  = 6 * TICK_DIV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ps2_clk = 1'b1;
    logic ps2_dat = 1'b1;
    logic [7:0] rx_byte;
    logic rx_valid, rx_err, rx_timeout;

    int checks = 0;
    int failures = 0;
    int n_valid = 0, n_err = 0, n_to = 0;
    logic [7:0] last_byte = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    ps2_rx_engine #(.TICK_DIV(TICK_DIV), .TIMEOUT_TICKS(TMO_TICKS)) uut (
        .clk(clk), .rst_n(rst_n), .ps2_clk_i(ps2_clk), .ps2_dat_i(ps2_dat),
        .rx_byte_o(rx_byte), .rx_valid_o(rx_valid), .rx_err_o(rx_err),
        .rx_timeout_o(rx_timeout)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin n_valid++; last_byte = rx_byte; end
            if (rx_err) n_err++;
            if (rx_timeout) n_to++;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic clear_counts();
        @(negedge clk);
        n_valid = 0; n_err = 0; n_to = 0;
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(posedge clk);
    endtask

    // drive nbits of a frame (start, 8 data, parity, stop); hold clock low after the last edge
    task automatic drive_bits(input logic [10:0] bits, input int nbits, input int hold_low);
        for (int i = 0; i < nbits; i++) begin
            ps2_dat = bits[i];
            wait_clks(HALF_CLKS);
            ps2_clk = 1'b0;
            wait_clks((i == nbits - 1) ? hold_low : HALF_CLKS);
            if (i != nbits - 1) ps2_clk = 1'b1;
        end
    endtask

    function automatic logic [10:0] frame(input logic [7:0] d, input bit bad_par, input bit stop);
        logic par;
        par = (~^d) ^ bad_par;
        return {stop, par, d, 1'b0};
    endfunction

    task automatic release_lines();
        ps2_clk = 1'b1;
        wait_clks(HALF_CLKS);
        ps2_dat = 1'b1;
        wait_clks(4 * TICK_DIV);
    endtask

    task automatic t_good(input logic [7:0] d, input string tag);
        clear_counts();
        drive_bits(frame(d, 1'b0, 1'b1), 11, HALF_CLKS);
        release_lines();
        check(n_valid == 1 && n_err == 0, tag, n_valid, 1);
        check(last_byte == d && rx_byte == d, tag, rx_byte, d);
    endtask

    task automatic t_reset();
        check(rx_byte == 8'h00, "R1 byte", rx_byte, 0);
        check(!rx_valid && !rx_err && !rx_timeout, "R1 strobes",
              {rx_valid, rx_err, rx_timeout}, 0);
    endtask

    task automatic t_bad_parity();
        logic [7:0] prev;
        prev = rx_byte;
        clear_counts();
        drive_bits(frame(8'h96, 1'b1, 1'b1), 11, HALF_CLKS);
        release_lines();
        check(n_err == 1 && n_valid == 0, "R4 parity error", n_err, 1);
        check(rx_byte == prev, "R8 byte held after error", rx_byte, prev);
    endtask

    task automatic t_bad_stop();
        clear_counts();
        drive_bits(frame(8'h21, 1'b0, 1'b0), 11, HALF_CLKS);
        release_lines();
        check(n_err == 1 && n_valid == 0, "R5 stop error", n_err, 1);
    endtask

    task automatic t_no_start();
        clear_counts();
        for (int i = 0; i < 3; i++) begin
            wait_clks(HALF_CLKS);
            ps2_clk = 1'b0;
            wait_clks(HALF_CLKS);
            ps2_clk = 1'b1;
        end
        wait_clks(4 * TICK_DIV);
        check(n_valid + n_err + n_to == 0, "R2 edge with data high ignored", n_valid + n_err, 0);
        t_good(8'hC3, "R2 frame after ignored edges");
    endtask

    task automatic t_hold_low();
        clear_counts();
        drive_bits(frame(8'h5A, 1'b0, 1'b1), 11, 30 * TICK_DIV);
        check(n_valid == 0 && n_err == 0, "R6 no strobe while clock low", n_valid, 0);
        release_lines();
        check(n_valid == 1 && rx_byte == 8'h5A, "R6 strobe after clock high", rx_byte, 8'h5A);
    endtask

    task automatic t_timeout();
        logic [7:0] prev;
        prev = rx_byte;
        clear_counts();
        drive_bits(frame(8'hFF, 1'b0, 1'b1), 4, HALF_CLKS);
        ps2_clk = 1'b1;
        ps2_dat = 1'b1;
        wait_clks((TMO_TICKS + 20) * TICK_DIV);
        check(n_to == 1 && n_valid == 0 && n_err == 0, "R7 timeout strobe", n_to, 1);
        check(rx_byte == prev, "R8 byte held after timeout", rx_byte, prev);
        t_good(8'h81, "R7 frame after timeout");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait_clks(5);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        wait_clks(10);
        t_reset();
        t_good(8'hA5, "R3 byte A5");
        t_good(8'h00, "R3 byte 00");
        t_good(8'hFF, "R3 byte FF");
        t_good(8'h01, "R3 byte 01 bit order");
        t_good(8'h80, "R3 byte 80 bit order");
        t_bad_parity();
        t_bad_stop();
        t_no_start();
        t_hold_low();
        t_timeout();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule